// File: doc/BRIEF.md
# Timestamped Cyclic Stimulus Buffer

This block is a circular queue that sits between a host that loads stimulus and a cycle-based simulation engine that consumes it. Each entry the host pushes carries a data word and the number of the simulated system cycle at which that data applies. Cycles with no data take no space in the queue, because an idle cycle is simply a cycle whose number matches no entry.

On every simulated system cycle the engine raises a tick strobe and supplies the current cycle number. The block offers the head entry only when its timestamp equals that number. Otherwise it offers nothing. When the engine cannot take a due entry, the entry stays at the head and remains due on later ticks. The host sees both pointers. It can throw away queued entries by moving the read pointer forward, without reading them. Two sticky flags record a push into a full queue and a tick against an empty queue. One instance serves each stimulus channel.

Top module: `ts_stim_buf`

## Requirements
- R1: After reset both pointers are zero, `empty` is 1, `full` is 0, both error flags are 0 and `sim_valid` is 0.
- R2: A `host_push` while not full stores {timestamp, data} at the slot indexed by the low bits of `wr_ptr`, and `wr_ptr` increases by one at the next edge. Entries come out in push order.
- R3: `sim_valid` is 1 only in a cycle where `sim_tick` is 1, the queue is not empty, `host_rptr_wr` is 0, and the head timestamp equals `sim_cycle` (or the head is already late, see R5). `sim_data` then shows the head data. In any other cycle `sim_valid` is 0 and nothing is removed.
- R4: When `sim_valid` and `sim_ready` are both 1, the head is removed and `rd_ptr` increases by one at the next edge.
- R5: When a due head is offered with `sim_ready` at 0, it is not removed. It is offered on every later tick whatever `sim_cycle` is, until it is accepted or discarded.
- R6: Pointers are one bit wider than the slot index. `empty` is 1 when the pointers are equal. `full` is 1 when the index bits are equal and the top bits differ, which means DEPTH entries are held.
- R7: A `host_push` while full is dropped, `wr_ptr` is unchanged, and `err_overrun` becomes 1 and stays 1.
- R8: A cycle with `sim_tick` at 1 and the queue empty sets `err_underrun`, which stays 1.
- R9: `host_rptr_wr` with a value whose distance ahead of `rd_ptr` is no more than the occupancy loads `rd_ptr` with that value at the next edge. This discards the skipped entries and clears the late state. `sim_valid` is 0 in that cycle.
- R10: `host_rptr_wr` with a value farther ahead than the occupancy is ignored, and `rd_ptr` is unchanged.
- R11: `host_err_clr` clears both error flags at the next edge. A new error event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_push | input | 1 | Push one entry |
| host_push_ts | input | TS_W | System cycle the pushed entry applies to |
| host_push_data | input | DATA_W | Data of the pushed entry |
| host_rptr_wr | input | 1 | Load a new read pointer (discard) |
| host_rptr_val | input | AW+1 | New read pointer value |
| host_err_clr | input | 1 | Clear both sticky error flags |
| wr_ptr | output | AW+1 | Write pointer with wrap bit |
| rd_ptr | output | AW+1 | Read pointer with wrap bit |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entry held |
| err_overrun | output | 1 | Sticky: push attempted while full |
| err_underrun | output | 1 | Sticky: tick seen while empty |
| sim_tick | input | 1 | A simulated system cycle is being evaluated |
| sim_cycle | input | TS_W | Current system cycle number |
| sim_ready | input | 1 | Consumer accepts the offered entry |
| sim_valid | output | 1 | Head entry offered this cycle |
| sim_data | output | DATA_W | Head entry data |

## Verification
`sim_valid` and `sim_data` are combinational from the stored state and the tick inputs. The bench therefore drives the simulation inputs just after a rising edge and samples the offer one nanosecond later, before the next edge. The pointers, `full`, `empty` and the error flags change at the edge that follows the push, accept, discard, tick or clear. These are checked one nanosecond after that edge. The late-head case is checked over two consecutive ticks with different cycle numbers. The wrap case fills all slots from a non-zero start index.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    typedef struct packed {
        logic overrun;
        logic underrun;
    } tsb_err_t;

endpackage

// File: rtl/tsb_store.sv
module tsb_store #(
    parameter int DATA_W = 8,
    parameter int TS_W   = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int ENT_W = TS_W + DATA_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [TS_W-1:0]   wts,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [TS_W-1:0]   rts,
    output logic [DATA_W-1:0] rdata
);

    logic [DEPTH-1:0][ENT_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = {wts, wdata};
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rts   = mem_q[raddr][ENT_W-1:DATA_W];
    assign rdata = mem_q[raddr][DATA_W-1:0];

endmodule

// File: rtl/tsb_ptrs.sv
module tsb_ptrs
    import tsb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PTR_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             disc_req,
    input  logic [PTR_W-1:0] disc_val,
    input  logic             tick,
    input  logic             err_clr,
    output logic             push_ok,
    output logic             disc_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full,
    output logic             empty,
    output tsb_err_t         err
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        tsb_err_t         err;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [PTR_W-1:0] occ;
    logic [PTR_W-1:0] disc_dist;

    always_comb begin
        empty     = (st_q.wr == st_q.rd);
        full      = (st_q.wr[AW-1:0] == st_q.rd[AW-1:0]) && (st_q.wr[AW] != st_q.rd[AW]);
        occ       = st_q.wr - st_q.rd;
        disc_dist = disc_val - st_q.rd;
        push_ok   = push_req && !full;
        disc_ok   = disc_req && (disc_dist <= occ);

        st_d = st_q;
        if (push_ok) begin
            st_d.wr = st_q.wr + 1'b1;
        end
        if (disc_ok) begin
            st_d.rd = disc_val;
        end else if (pop_req && !disc_req) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        st_d.err.overrun  = (st_q.err.overrun && !err_clr) || (push_req && full);
        st_d.err.underrun = (st_q.err.underrun && !err_clr) || (tick && empty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign err    = st_q.err;

endmodule

// File: rtl/tsb_head.sv
module tsb_head #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            empty,
    input  logic [TS_W-1:0] head_ts,
    input  logic            tick,
    input  logic [TS_W-1:0] cycle,
    input  logic            ready,
    input  logic            disc_req,
    input  logic            disc_ok,
    output logic            offer,
    output logic            pop
);

    logic late_d, late_q;

    always_comb begin
        offer = tick && !empty && !disc_req && (late_q || (head_ts == cycle));
        pop   = offer && ready;

        late_d = late_q;
        if (disc_ok || pop) begin
            late_d = 1'b0;
        end else if (offer && !ready) begin
            late_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            late_q <= 1'b0;
        end else begin
            late_q <= late_d;
        end
    end

endmodule

// File: rtl/ts_stim_buf.sv
module ts_stim_buf
    import tsb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TS_W   = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PTR_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_push,
    input  logic [TS_W-1:0]   host_push_ts,
    input  logic [DATA_W-1:0] host_push_data,
    input  logic              host_rptr_wr,
    input  logic [PTR_W-1:0]  host_rptr_val,
    input  logic              host_err_clr,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              full,
    output logic              empty,
    output logic              err_overrun,
    output logic              err_underrun,
    input  logic              sim_tick,
    input  logic [TS_W-1:0]   sim_cycle,
    input  logic              sim_ready,
    output logic              sim_valid,
    output logic [DATA_W-1:0] sim_data
);

    logic      push_ok;
    logic      disc_ok;
    logic      pop;
    logic [TS_W-1:0] head_ts;
    tsb_err_t  err;

    tsb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (host_push),
        .pop_req  (pop),
        .disc_req (host_rptr_wr),
        .disc_val (host_rptr_val),
        .tick     (sim_tick),
        .err_clr  (host_err_clr),
        .push_ok  (push_ok),
        .disc_ok  (disc_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .full     (full),
        .empty    (empty),
        .err      (err)
    );

    tsb_store #(.DATA_W(DATA_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr[AW-1:0]),
        .wts   (host_push_ts),
        .wdata (host_push_data),
        .raddr (rd_ptr[AW-1:0]),
        .rts   (head_ts),
        .rdata (sim_data)
    );

    tsb_head #(.TS_W(TS_W)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .empty    (empty),
        .head_ts  (head_ts),
        .tick     (sim_tick),
        .cycle    (sim_cycle),
        .ready    (sim_ready),
        .disc_req (host_rptr_wr),
        .disc_ok  (disc_ok),
        .offer    (sim_valid),
        .pop      (pop)
    );

    assign err_overrun  = err.overrun;
    assign err_underrun = err.underrun;

endmodule

// File: rtl/ts_stim_buf_chk.sv
module ts_stim_buf_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_push,
    input logic             host_rptr_wr,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             full,
    input logic             empty,
    input logic             err_overrun,
    input logic             err_underrun,
    input logic             sim_tick,
    input logic             sim_ready,
    input logic             sim_valid
);

    // R3
    no_offer_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sim_valid |-> (!empty && sim_tick));

    // R4
    accept_advances_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_valid && sim_ready) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

    // R5
    stalled_head_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_valid && !sim_ready) |=> (rd_ptr == $past(rd_ptr)));

    // R5
    stalled_head_reoffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_tick && !host_rptr_wr && $past(sim_valid && !sim_ready)) |-> sim_valid);

    // R6
    full_empty_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R7
    overrun_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_push && full) |=> (err_overrun && wr_ptr == $past(wr_ptr)));

    // R8
    underrun_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_tick && empty) |=> err_underrun);

    // R9
    no_offer_during_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rptr_wr |-> !sim_valid);

endmodule

bind ts_stim_buf ts_stim_buf_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_push    (host_push),
    .host_rptr_wr (host_rptr_wr),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .full         (full),
    .empty        (empty),
    .err_overrun  (err_overrun),
    .err_underrun (err_underrun),
    .sim_tick     (sim_tick),
    .sim_ready    (sim_ready),
    .sim_valid    (sim_valid)
);

// File: tb/ts_stim_buf_test.sv
`timescale 1ns/1ps
module ts_stim_buf_test;

    localparam int DATA_W = 8;
    localparam int TS_W   = 8;
    localparam int DEPTH  = 8;
    localparam int PTR_W  = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_push = 1'b0;
    logic [TS_W-1:0]   host_push_ts = '0;
    logic [DATA_W-1:0] host_push_data = '0;
    logic              host_rptr_wr = 1'b0;
    logic [PTR_W-1:0]  host_rptr_val = '0;
    logic              host_err_clr = 1'b0;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, empty, err_overrun, err_underrun;
    logic              sim_tick = 1'b0;
    logic [TS_W-1:0]   sim_cycle = '0;
    logic              sim_ready = 1'b0;
    logic              sim_valid;
    logic [DATA_W-1:0] sim_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    ts_stim_buf #(.DATA_W(DATA_W), .TS_W(TS_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_push(host_push), .host_push_ts(host_push_ts), .host_push_data(host_push_data),
        .host_rptr_wr(host_rptr_wr), .host_rptr_val(host_rptr_val), .host_err_clr(host_err_clr),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty),
        .err_overrun(err_overrun), .err_underrun(err_underrun),
        .sim_tick(sim_tick), .sim_cycle(sim_cycle), .sim_ready(sim_ready),
        .sim_valid(sim_valid), .sim_data(sim_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int ts, input int data);
        host_push      = 1'b1;
        host_push_ts   = TS_W'(ts);
        host_push_data = DATA_W'(data);
        edge_step();
        host_push = 1'b0;
    endtask

    // One tick: check the offer before the edge, leave state for the caller.
    task automatic tick(input int cyc, input bit rdy, input int exp_valid, input int exp_data,
                        input string req);
        sim_tick  = 1'b1;
        sim_cycle = TS_W'(cyc);
        sim_ready = rdy;
        #1;
        check({req, " valid"}, int'(sim_valid), exp_valid);
        if (exp_valid == 1) check({req, " data"}, int'(sim_data), exp_data);
        edge_step();
        sim_tick  = 1'b0;
        sim_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 wr_ptr", int'(wr_ptr), 0);
        check("R1 rd_ptr", int'(rd_ptr), 0);
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 overrun", int'(err_overrun), 0);
        check("R1 underrun", int'(err_underrun), 0);
        check("R1 valid", int'(sim_valid), 0);
    endtask

    task automatic t_timing();
        push(5, 8'hA1);
        push(7, 8'hB2);
        push(8, 8'hC3);
        check("R2 wr_ptr", int'(wr_ptr), 3);
        check("R2 empty", int'(empty), 0);
        sim_cycle = 8'd5;
        #1;
        check("R3 no tick", int'(sim_valid), 0);
        tick(4, 1'b1, 0, 0, "R3 early");
        check("R3 early rd", int'(rd_ptr), 0);
        tick(5, 1'b1, 1, 8'hA1, "R3 due");
        check("R4 rd after accept", int'(rd_ptr), 1);
        tick(6, 1'b1, 0, 0, "R3 gap");
        tick(7, 1'b0, 1, 8'hB2, "R5 stall");
        check("R5 rd held", int'(rd_ptr), 1);
        tick(8, 1'b0, 1, 8'hB2, "R5 late offer");
        tick(9, 1'b1, 1, 8'hB2, "R5 late accept");
        check("R4 rd", int'(rd_ptr), 2);
        tick(10, 1'b1, 0, 0, "R3 stale head");
        check("R2 order rd", int'(rd_ptr), 2);
    endtask

    task automatic t_discard();
        push(12, 8'hD4);
        host_rptr_wr  = 1'b1;
        host_rptr_val = PTR_W'(3);
        sim_tick  = 1'b1;
        sim_cycle = 8'd8;
        sim_ready = 1'b1;
        #1;
        check("R9 valid off", int'(sim_valid), 0);
        edge_step();
        host_rptr_wr = 1'b0;
        sim_tick = 1'b0;
        sim_ready = 1'b0;
        check("R9 rd loaded", int'(rd_ptr), 3);
        host_rptr_wr  = 1'b1;
        host_rptr_val = PTR_W'(6);
        edge_step();
        host_rptr_wr = 1'b0;
        check("R10 rd kept", int'(rd_ptr), 3);
        tick(12, 1'b1, 1, 8'hD4, "R9 next head");
        check("R6 empty", int'(empty), 1);
    endtask

    task automatic t_errors();
        check("R8 before", int'(err_underrun), 0);
        tick(13, 1'b1, 0, 0, "R8 empty tick");
        check("R8 underrun", int'(err_underrun), 1);
        edge_step();
        check("R8 sticky", int'(err_underrun), 1);
        host_err_clr = 1'b1;
        edge_step();
        host_err_clr = 1'b0;
        check("R11 cleared", int'(err_underrun), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH - 1; i++) push(20 + i, 16 + i);
        check("R6 not full", int'(full), 0);
        push(27, 8'h17);
        check("R6 full", int'(full), 1);
        check("R6 wr wrap", int'(wr_ptr), 12);
        push(28, 8'h99);
        check("R7 wr kept", int'(wr_ptr), 12);
        check("R7 overrun", int'(err_overrun), 1);
        edge_step();
        check("R7 sticky", int'(err_overrun), 1);
        tick(20, 1'b1, 1, 8'h10, "R2 first of fill");
        check("R6 not full after pop", int'(full), 0);
        host_rptr_wr  = 1'b1;
        host_rptr_val = PTR_W'(12);
        edge_step();
        host_rptr_wr = 1'b0;
        check("R9 drain", int'(empty), 1);
        push(30, 8'h55);
        tick(30, 1'b1, 1, 8'h55, "R2 wrapped slot");
        host_err_clr = 1'b1;
        edge_step();
        host_err_clr = 1'b0;
        check("R11 overrun cleared", int'(err_overrun), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        edge_step();
        t_reset();
        t_timing();
        t_discard();
        t_errors();
        t_full();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule